// File: doc/BRIEF.md
# Auto-Reload Interval Timer

A single-channel countdown timer sitting on a simple memory-mapped register port. Software loads a period into an interval register. It then starts the channel through a control word that holds an enable bit, a self-clearing reload strobe, a one-shot bit, a two-bit time-base select and a three-bit divider field. Each time the count runs out, a sticky status flag is set. The interrupt line is that flag gated by a global enable bit.

In periodic mode the counter refills from the interval register on every expiry, so the flag recurs at a fixed rate. In one-shot mode the counter parks at zero and the channel disables itself. Software may also write the live count directly and then enable the channel, so that the first timeout differs from the steady period.

The register port is a plain single-cycle write strobe with a combinational read path. There is no streaming data, so no valid/ready handshake exists; every access completes in the cycle it is presented.

Top module: `ivl_timer`

## Requirements
- R1: After reset every register (offsets 0x00, 0x04, 0x10, 0x14, 0x18) reads zero and `irq` is low.
- R2: The interval register (0x14, full width) and the global enable bit (0x00 bit 0) read back what was written; the control word at 0x10 reads back its fields: bit 0 enable, bit 1 reload, bits [3:2] time-base select, bits [6:4] divider, bit 7 one-shot.
- R3: A control write with bit 1 set makes bit 1 read 1 until the next clock edge. At that edge the interval value is copied into the count (0x18) and bit 1 returns to 0.
- R4: With divider field value d, the count steps once every 2^d selected time-base ticks; after a reload-start with interval N, the status bit first reads 1 exactly 1 + N·2^d clock edges after the control write.
- R5: In periodic mode (bit 7 clear) the count refills from the interval register at each expiry, so expiries recur every N·2^d edges.
- R6: In one-shot mode (bit 7 set) the count stops at 0 at expiry, control bit 0 clears (so the control word reads 0x80 for a 0x83 start), and no further expiry occurs.
- R7: While control bit 0 is 0 the count holds its value.
- R8: Writing the count register and then writing control with enable set and reload clear starts the countdown from the written value: the first expiry follows after value·2^d edges, later ones after interval·2^d.
- R9: Status bit 0 (0x04) is set at each expiry and cleared by writing 1 to bit 0; when an expiry and that clear fall on the same edge, the bit stays 1.
- R10: `irq` equals status bit 0 AND global enable bit 0.
- R11: Control bits [3:2] select which bit of `src_tick` serves as the time base; ticks on other bits have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_tick | input | 4 | Candidate time-base tick enables |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a write to the count register and a reload strobe can coincide, with the direct write taking precedence, and that the selected time-base input is sampled synchronously with `clk`. The stimulus keeps the selected tick held high so that every edge is a time-base tick, which makes every expiry edge an exact product of interval and divider. It ties the unselected inputs low, so that a wrong select shows as a frozen count. All register writes are driven between edges, one per cycle, so no access overlaps another.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int PS_W  = 3;
  localparam int SRC_W = 2;
  localparam int NSRC  = 1 << SRC_W;
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam int CTL_W = 3 + PS_W + SRC_W;

  localparam logic [7:0] A_GCTL = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_CTL  = 8'h10;
  localparam logic [7:0] A_IVL  = 8'h14;
  localparam logic [7:0] A_CNT  = 8'h18;

  typedef struct packed {
    logic             oneshot;
    logic [PS_W-1:0]  psel;
    logic [SRC_W-1:0] ssel;
    logic             reload;
    logic             en;
  } ctl_t;
endpackage

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
  import ivl_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] cur_count,
  input  logic          expire,
  input  logic          stop_req,
  output logic          cnt_wr,
  output ctl_t          ctl_q,
  output logic          presc_clr,
  output logic [DW-1:0] interval,
  output logic          irq
);
  logic gie_q;
  logic stat_q;
  logic wr_gctl, wr_stat, wr_ctl, wr_ivl;
  logic ack;

  always_comb begin
    wr_gctl = bus_wr && (bus_addr == A_GCTL);
    wr_stat = bus_wr && (bus_addr == A_STAT);
    wr_ctl  = bus_wr && (bus_addr == A_CTL);
    wr_ivl  = bus_wr && (bus_addr == A_IVL);
    cnt_wr  = bus_wr && (bus_addr == A_CNT);
    ack     = wr_stat && bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      stat_q   <= 1'b0;
      ctl_q    <= '0;
      interval <= '0;
    end else begin
      if (wr_gctl) gie_q <= bus_wdata[0];
      if (expire)   stat_q <= 1'b1;
      else if (ack) stat_q <= 1'b0;
      if (wr_ctl) begin
        ctl_q <= ctl_t'(bus_wdata[CTL_W-1:0]);
      end else begin
        ctl_q.reload <= 1'b0;
        if (stop_req) ctl_q.en <= 1'b0;
      end
      if (wr_ivl) interval <= bus_wdata;
    end
  end

  assign presc_clr = wr_ctl || ctl_q.reload;
  assign irq       = stat_q && gie_q;

  always_comb begin
    unique case (bus_addr)
      A_GCTL:  bus_rdata = DW'(gie_q);
      A_STAT:  bus_rdata = DW'(stat_q);
      A_CTL:   bus_rdata = DW'(ctl_q);
      A_IVL:   bus_rdata = interval;
      A_CNT:   bus_rdata = cur_count;
      default: bus_rdata = '0;
    endcase
  end

  // R9
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat_q);
  // R9
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q && !ack |=> stat_q);
  // R3
  reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.reload && !wr_ctl |=> !ctl_q.reload);
  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && !wr_ctl |=> !ctl_q.en);
endmodule

// File: rtl/ivl_timer_presc.sv
module ivl_timer_presc
  import ivl_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [SRC_W-1:0] ssel,
  input  logic [PS_W-1:0]  psel,
  input  logic [NSRC-1:0]  src_tick,
  output logic             pulse
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             sel_tick;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (ssel == SRC_W'(i)) sel_tick = src_tick[i];
    end
    mask  = ~({DIV_W{1'b1}} << psel);
    pulse = en && !clr && sel_tick && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              div_q <= '0;
    else if (clr)            div_q <= '0;
    else if (en && sel_tick) div_q <= div_q + 1'b1;
  end

  // R11
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> sel_tick && en);
  // R4
  div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !(en && sel_tick) |=> $stable(div_q));
endmodule

// File: rtl/ivl_timer_cnt.sv
module ivl_timer_cnt #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          oneshot,
  input  logic          tick,
  input  logic          reload_go,
  input  logic [DW-1:0] interval,
  input  logic          cnt_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] count,
  output logic          expire,
  output logic          stop_req
);
  logic step;

  always_comb begin
    step     = en && tick && !cnt_wr && !reload_go;
    expire   = step && (count <= DW'(1));
    stop_req = expire && oneshot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         count <= '0;
    else if (cnt_wr)    count <= wdata;
    else if (reload_go) count <= interval;
    else if (expire)    count <= oneshot ? '0 : interval;
    else if (step)      count <= count - 1'b1;
  end

  // R3
  reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_go && !cnt_wr |=> count == $past(interval));
  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !cnt_wr && !reload_go |=> $stable(count));
  // R6
  oneshot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> count == '0);
  // R5
  periodic_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !oneshot |=> count == $past(interval));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  output logic            irq
);
  ctl_t          ctl;
  logic          cnt_wr, presc_clr, pulse, expire, stop_req;
  logic [DW-1:0] interval, count;

  ivl_timer_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cur_count(count),
    .expire(expire), .stop_req(stop_req), .cnt_wr(cnt_wr), .ctl_q(ctl),
    .presc_clr(presc_clr), .interval(interval), .irq(irq)
  );

  ivl_timer_presc presc_i (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .clr(presc_clr),
    .ssel(ctl.ssel), .psel(ctl.psel), .src_tick(src_tick), .pulse(pulse)
  );

  ivl_timer_cnt #(.DW(DW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .oneshot(ctl.oneshot),
    .tick(pulse), .reload_go(ctl.reload), .interval(interval),
    .cnt_wr(cnt_wr), .wdata(bus_wdata), .count(count), .expire(expire),
    .stop_req(stop_req)
  );
endmodule

// File: tb/ivl_timer_tb_top.sv
module ivl_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] GCTL = 8'h00, STAT = 8'h04, CTL = 8'h10,
                         IVL = 8'h14, CNT = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = 4'b0001;
  logic        irq;
  int          errors = 0;
  int          checks = 0;

  ivl_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
    .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_stat(input int start, output int n);
    n = start;
    bus_addr = STAT;
    do begin
      @(posedge clk); #1; n++;
    end while (!bus_rdata[0] && n < 3000);
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL R4 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    int n;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(GCTL, v); chk("R1 gctl", v, 0);
    rd(STAT, v); chk("R1 stat", v, 0);
    rd(CTL, v);  chk("R1 ctl", v, 0);
    rd(IVL, v);  chk("R1 ivl", v, 0);
    rd(CNT, v);  chk("R1 cnt", v, 0);
    chk("R1 irq", irq, 0);

    // R2 readback
    wr(IVL, 32'hA5C3_0F81); rd(IVL, v); chk("R2 ivl", v, 32'hA5C3_0F81);
    wr(GCTL, 1); rd(GCTL, v); chk("R2 gctl", v, 1);
    wr(CTL, 32'h6C); rd(CTL, v); chk("R2 ctl", v, 32'h6C);

    // R4 / R5 / R9 sweep over divider and interval
    for (int ps = 0; ps < 8; ps++) begin
      for (int ni = 0; ni < 4; ni++) begin
        int nval, per;
        nval = (ni == 0) ? 1 : (ni == 1) ? 2 : (ni == 2) ? 3 : 7;
        per  = nval << ps;
        wr(CTL, 0); wr(STAT, 1); wr(IVL, nval);
        wr(CTL, 32'(3 | (ps << 4)));
        wait_stat(0, n);
        chk("R4 first expiry", n, per + 1);
        chk("R10 irq on", irq, 1);
        wr(STAT, 1);
        rd(STAT, v);
        chk("R9 clear vs same-edge expiry", v[0], (per == 1) ? 1 : 0);
        if (per > 1) begin
          wait_stat(1, n);
          chk("R5 period", n, per);
        end
      end
    end
    wr(CTL, 0);

    // R10 gating
    wr(GCTL, 0); rd(STAT, v);
    chk("R10 stat held", v[0], 1); chk("R10 irq gated", irq, 0);
    wr(GCTL, 1); chk("R10 irq ungated", irq, 1);
    wr(STAT, 1); chk("R10 irq after clear", irq, 0);

    // R3 reload strobe
    wr(IVL, 9); wr(CTL, 32'h73);
    rd(CTL, v); chk("R3 reload visible", v, 32'h73);
    idle(1);
    rd(CTL, v); chk("R3 reload self-clear", v, 32'h71);
    rd(CNT, v); chk("R3 copied", v, 9);

    // R6 one-shot
    wr(CTL, 0); wr(STAT, 1); wr(IVL, 4); wr(CTL, 32'h83);
    wait_stat(0, n); chk("R6 expiry", n, 5);
    rd(CTL, v); chk("R6 enable cleared", v, 32'h80);
    rd(CNT, v); chk("R6 count parked", v, 0);
    wr(STAT, 1); idle(20);
    rd(STAT, v); chk("R6 no re-expiry", v[0], 0);
    rd(CNT, v); chk("R6 count still 0", v, 0);

    // R11 unselected source has no effect
    wr(CTL, 0); wr(IVL, 6); wr(CNT, 10); wr(CTL, 32'h05); idle(20);
    rd(CNT, v); chk("R11 count frozen", v, 10);
    rd(STAT, v); chk("R11 no expiry", v[0], 0);
    wr(CTL, 32'h01); idle(3);
    rd(CNT, v); chk("R11 source 0 counts", v, 7);

    // R8 direct count start
    wr(CTL, 0); wr(STAT, 1); wr(CNT, 3); wr(CTL, 32'h01);
    wait_stat(0, n); chk("R8 first from written value", n, 3);
    wr(STAT, 1); wait_stat(1, n); chk("R8 then interval", n, 6);

    // R7 halt
    wr(CTL, 0); rd(CNT, a); idle(15);
    rd(CNT, v); chk("R7 count held", v, a);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule